// File: doc/BRIEF.md
# SPI Byte Memory Command Engine

This block is an SPI slave in front of a byte-wide memory array held inside the block. It works on the system clock and samples the chip select, serial clock and serial input pins through a short synchronizer. It turns the serial stream into commands: an 8-bit opcode, then for memory commands a 16-bit address, then one or more data bytes. Reads stream array bytes out on the serial output. Writes commit each complete byte and step to the next address, wrapping at the top of the array. The serial output is driven only while there is data to return.

Write permission and the status byte belong to a separate status and protection unit. The engine reports write-enable set and clear requests and status write requests to that unit. It also presents the address of the pending byte write and drops the write when the unit answers that the address is blocked. For status reads it shifts out the status byte the unit supplies. The array depth is set by the parameter `AW`. The wire format always carries 16 address bits, and only the low `AW` bits select a byte. The default `AW = 11` keeps the array at 2048 bytes, and `AW = 15` gives the full 32K x 8 array.

Top module: `spi_mem_engine`

## Requirements
- R1: While chip select is high, `miso_oe` is 0, `miso` is 0, and no serial clock edge has any effect. Each low period of chip select starts a new command with the opcode.
- R2: Opcode 0x06 produces exactly one single-cycle pulse on `wen_set`. Opcode 0x04 produces exactly one single-cycle pulse on `wen_clr`.
- R3: After opcode 0x05, the engine shifts out the 8-bit `status_in` MSB first, and repeats it for every further byte of clocks. Each repeat takes the value `status_in` has at the start of that byte.
- R4: After opcode 0x01 and 8 data bits, `status_wr` pulses once for one cycle with `status_wdata` equal to the received byte. Bytes after that first one are ignored.
- R5: Opcode 0x02 takes a 16-bit address, MSB first. Address bits at and above `AW` are don't-care. Every complete 8-bit byte that follows is written, the first at the given address and each later one at the next address.
- R6: Opcode 0x03 takes a 16-bit address in the same way. The engine then returns the byte at that address and at each following address, MSB first, for as long as clocks continue. Each output bit changes after a falling serial clock edge.
- R7: For both reads and writes, the address counter wraps from 2^AW-1 (0x7FF by default) to 0.
- R8: If chip select rises before all 8 opcode bits have been clocked in, nothing is executed. If chip select rises in the middle of a write data byte, that partial byte is discarded and the array is unchanged.
- R9: Any opcode other than 0x01 to 0x06 is ignored for the rest of that select period: no pulse, no write, and no output enable.
- R10: `miso_oe` is 1 only during the data phase of opcodes 0x03 and 0x05.
- R11: Before each byte write, `prot_addr` carries the target address. When `prot_block` is 1 the byte is silently dropped, but the address still advances.
- R12: Both idle clock levels work (SPI mode 0 and mode 3). Input is sampled on rising serial clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the serial data out pad |
| prot_addr | output | AW | Address of the pending byte write |
| prot_block | input | 1 | 1 = write to `prot_addr` is not allowed |
| status_in | input | 8 | Status byte returned by opcode 0x05 |
| wen_set | output | 1 | Write-enable set request pulse |
| wen_clr | output | 1 | Write-enable clear request pulse |
| status_wr | output | 1 | Status write request pulse |
| status_wdata | output | 8 | Byte for the status write |

## Verification
Each pin change is seen by the logic after two synchronizer stages and one edge register. The request pulses and the array writes therefore happen three clock edges after the eighth rising serial clock edge of a byte, and a new `miso` bit appears three edges after a falling edge. The bench holds each serial clock level for four system clocks and reads `miso` and `miso_oe` just before it raises the serial clock. In that way every output has settled when it is sampled. The effect of a write is always checked through a later read burst, so a write that was dropped, partial or ignored shows up at the ports.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STATUS_RD = 8'h05;
  localparam logic [7:0] OP_STATUS_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD    = 8'h03;
  localparam logic [7:0] OP_MEM_WR    = 8'h02;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_WR_DATA,
    PH_RD_DATA,
    PH_ST_DATA,
    PH_ST_WRITE,
    PH_DISCARD
  } phase_e;

  // phase entered after a complete opcode byte
  function automatic phase_e decode_op(input logic [7:0] op);
    case (op)
      OP_MEM_RD, OP_MEM_WR: return PH_ADDR_HI;
      OP_STATUS_RD:         return PH_ST_DATA;
      OP_STATUS_WR:         return PH_ST_WRITE;
      default:              return PH_DISCARD;
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] RST_VAL = 3'b001; // {mosi, sck, cs_n}

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic            sck_prev;

  assign pin_raw = {mosi, sck, cs_n};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[p]}};
      else        chain <= {chain[STAGES-2:0], pin_raw[p]};
    end
    assign pin_s[p] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= pin_s[1];
  end

  assign cs_act   = ~pin_s[0];
  assign sck_rise = pin_s[1] & ~sck_prev;
  assign sck_fall = ~pin_s[1] & sck_prev;
  assign mosi_s   = pin_s[2];

endmodule

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_mem_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    status_i,
  input  logic          blocked_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o,
  output logic          wen_set_o,
  output logic          wen_clr_o,
  output logic          status_wr_o,
  output logic [7:0]    status_wdata_o,
  output logic          miso_o,
  output logic          miso_oe_o
);
  localparam int WIRE_AW = 16;

  phase_e        phase;
  logic [2:0]    bit_cnt;
  logic [6:0]    shin;
  logic [7:0]    addr_hi;
  logic [AW-1:0] addr;
  logic [6:0]    shout;
  logic          miso_q;
  logic          cmd_is_read;

  function automatic logic [AW-1:0] bump_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] take_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic [WIRE_AW-1:0] full;
    full = {hi, lo};
    return full[AW-1:0];
  endfunction

  // named internal events
  logic [7:0] byte_in;
  logic       byte_done;
  logic       out_phase;
  logic [7:0] out_src;

  assign byte_in   = {shin, mosi_s};
  assign byte_done = cs_act && sck_rise && (bit_cnt == 3'd7);
  assign out_phase = (phase == PH_RD_DATA) || (phase == PH_ST_DATA);
  assign out_src   = (phase == PH_RD_DATA) ? rd_data : status_i;

  assign mem_addr_o     = addr;
  assign mem_wdata_o    = byte_in;
  assign mem_we_o       = byte_done && (phase == PH_WR_DATA) && !blocked_i;
  assign wen_set_o      = byte_done && (phase == PH_OPCODE) && (byte_in == OP_LATCH_SET);
  assign wen_clr_o      = byte_done && (phase == PH_OPCODE) && (byte_in == OP_LATCH_CLR);
  assign status_wr_o    = byte_done && (phase == PH_ST_WRITE);
  assign status_wdata_o = byte_in;
  assign miso_o         = miso_q;
  assign miso_oe_o      = cs_act && out_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_OPCODE;
      bit_cnt     <= 3'd0;
      shin        <= 7'd0;
      addr_hi     <= 8'd0;
      addr        <= '0;
      shout       <= 7'd0;
      miso_q      <= 1'b0;
      cmd_is_read <= 1'b0;
    end else if (!cs_act) begin
      phase   <= PH_OPCODE;
      bit_cnt <= 3'd0;
      shin    <= 7'd0;
      miso_q  <= 1'b0;
    end else begin
      if (sck_rise) begin
        shin    <= byte_in[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        case (phase)
          PH_OPCODE: begin
            phase       <= decode_op(byte_in);
            cmd_is_read <= (byte_in == OP_MEM_RD);
          end
          PH_ADDR_HI: begin
            addr_hi <= byte_in;
            phase   <= PH_ADDR_LO;
          end
          PH_ADDR_LO: begin
            addr  <= take_addr(addr_hi, byte_in);
            phase <= cmd_is_read ? PH_RD_DATA : PH_WR_DATA;
          end
          PH_WR_DATA, PH_RD_DATA: addr <= bump_addr(addr);
          PH_ST_WRITE:            phase <= PH_DISCARD;
          default: ;
        endcase
      end
      if (sck_fall && out_phase) begin
        if (bit_cnt == 3'd0) {miso_q, shout} <= out_src;
        else                 {miso_q, shout} <= {shout, 1'b0};
      end
    end
  end

  // R7: every completed data byte moves the counter one step, wrapping
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_WR_DATA || phase == PH_RD_DATA))
      |=> (addr == bump_addr($past(addr))));

  // R2: request pulses last one cycle
  p_set_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wen_set_o |=> !wen_set_o);

  // R9: at most one side effect per cycle
  p_ctl_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wen_set_o, wen_clr_o, status_wr_o, mem_we_o}));

  // R8: deselect returns the engine to opcode collection
  p_idle_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase == PH_OPCODE && bit_cnt == 3'd0 && !miso_oe_o));

  // R6: output bit moves only after a falling edge or a deselect
  p_miso_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sck_fall) && $past(cs_act)) |-> $stable(miso_q));

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
  parameter int AW          = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] prot_addr,
  input  logic          prot_block,
  input  logic [7:0]    status_in,
  output logic          wen_set,
  output logic          wen_clr,
  output logic          status_wr,
  output logic [7:0]    status_wdata
);
  logic          cs_act, sck_rise, sck_fall, mosi_s;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [7:0]    mem_wdata, mem_rdata;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  spi_cmd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .rd_data(mem_rdata),
    .status_i(status_in), .blocked_i(prot_block), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .wen_set_o(wen_set),
    .wen_clr_o(wen_clr), .status_wr_o(status_wr),
    .status_wdata_o(status_wdata), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  spi_byte_ram #(.AW(AW)) u_ram (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  assign prot_addr = mem_addr;

endmodule

// File: tb/spi_mem_engine_test.sv
`timescale 1ns/1ps
module spi_mem_engine_test;
  localparam int AW   = 11;
  localparam int MASK = (1 << AW) - 1;
  localparam int H    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic [AW-1:0] prot_addr;
  logic prot_block;
  logic [7:0] status_in = 8'h00;
  logic wen_set, wen_clr, status_wr;
  logic [7:0] status_wdata;

  int checks = 0, errors = 0;
  int n_set = 0, n_clr = 0, n_swr = 0;
  logic [7:0] last_swr = 8'h00;
  int blk_lo = 0, blk_hi = 0;
  logic mode3 = 1'b0;
  logic [7:0] model_mem [0:MASK];

  always #2.5 clk = ~clk;

  spi_mem_engine uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .prot_addr(prot_addr),
    .prot_block(prot_block), .status_in(status_in), .wen_set(wen_set),
    .wen_clr(wen_clr), .status_wr(status_wr), .status_wdata(status_wdata)
  );

  function automatic logic is_blk(input int a);
    return (a >= blk_lo) && (a < blk_hi);
  endfunction

  assign prot_block = is_blk(int'(prot_addr));

  always @(posedge clk) begin
    if (wen_set) n_set <= n_set + 1;
    if (wen_clr) n_clr <= n_clr + 1;
    if (status_wr) begin
      n_swr <= n_swr + 1;
      last_swr <= status_wdata;
    end
  end

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'(((a * 29) + salt) ^ (a >> 4));
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    sck = mode3;
    tick(4);
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic desel();
    if (!mode3) sck = 1'b0;
    tick(H);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx, output logic oe_any);
    rx = 8'h00;
    oe_any = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0;
      mosi = tx[i];
      tick(H);
      rx[i] = miso;
      oe_any = oe_any | miso_oe;
      sck = 1'b1;
      tick(H);
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    bits(tx, 8, rx, oe_any);
  endtask

  task automatic write_burst(input logic [15:0] a, input int n, input int salt);
    logic [7:0] rx;
    logic oe, oe_all;
    oe_all = 1'b0;
    sel();
    xb(8'h02, rx, oe); oe_all |= oe;
    xb(a[15:8], rx, oe); oe_all |= oe;
    xb(a[7:0], rx, oe); oe_all |= oe;
    for (int k = 0; k < n; k++) begin
      int ad;
      ad = (int'(a) + k) & MASK;
      xb(pat(ad, salt), rx, oe); oe_all |= oe;
      if (!is_blk(ad)) model_mem[ad] = pat(ad, salt);
    end
    desel();
    chk(oe_all == 1'b0, "R10 no output enable during write", int'(oe_all), 0);
  endtask

  task automatic read_burst(input logic [15:0] a, input int n, input string req);
    logic [7:0] rx;
    logic oe, oe_hdr;
    oe_hdr = 1'b0;
    sel();
    xb(8'h03, rx, oe); oe_hdr |= oe;
    xb(a[15:8], rx, oe); oe_hdr |= oe;
    xb(a[7:0], rx, oe); oe_hdr |= oe;
    chk(oe_hdr == 1'b0, "R10 output enable off in opcode/address", int'(oe_hdr), 0);
    for (int k = 0; k < n; k++) begin
      int ad;
      ad = (int'(a) + k) & MASK;
      xb(8'h00, rx, oe);
      chk(rx === model_mem[ad], req, int'(rx), int'(model_mem[ad]));
      if (k == 0) chk(oe == 1'b1, "R10 output enable in read data", int'(oe), 1);
    end
    desel();
  endtask

  initial begin
    logic [7:0] rx;
    logic oe;
    int s0, c0, w0;
    tick(5);
    // R1 reset/idle state
    chk(miso_oe == 1'b0, "R1 idle oe", int'(miso_oe), 0);
    chk(miso == 1'b0, "R1 idle miso", int'(miso), 0);
    rst_n = 1'b1;
    tick(5);
    // R1: clocks while deselected do nothing
    for (int i = 0; i < 8; i++) begin
      mosi = 1'b1; sck = 1'b1; tick(H); sck = 1'b0; tick(H);
    end
    chk(miso_oe == 1'b0 && n_set == 0 && n_swr == 0, "R1 ignored while deselected",
        int'(miso_oe), 0);

    // R5 R7 R12: long write in mode 0 across the wrap, top address bits set
    mode3 = 1'b0;
    write_burst(16'hF700, 512, 11);
    // R6 R7 R12: read back in mode 3
    mode3 = 1'b1;
    read_burst(16'h0700, 512, "R6 R7 read burst across wrap");

    // R2 set / clear pulses
    s0 = n_set; c0 = n_clr;
    sel(); xb(8'h06, rx, oe); desel();
    chk(n_set == s0 + 1 && n_clr == c0, "R2 set pulse", n_set - s0, 1);
    mode3 = 1'b0;
    sel(); xb(8'h04, rx, oe); desel();
    chk(n_clr == c0 + 1 && n_set == s0 + 1, "R2 clear pulse", n_clr - c0, 1);

    // R8 truncated opcode
    s0 = n_set;
    sel(); bits(8'h06, 5, rx, oe); desel();
    chk(n_set == s0, "R8 truncated opcode", n_set - s0, 0);
    sel(); xb(8'h06, rx, oe); desel();
    chk(n_set == s0 + 1, "R8 next command after truncation", n_set - s0, 1);

    // R3 status read, repeated, with update between bytes
    status_in = 8'hA5;
    sel();
    xb(8'h05, rx, oe);
    chk(oe == 1'b0, "R10 oe off during status opcode", int'(oe), 0);
    xb(8'h00, rx, oe);
    chk(rx == 8'hA5, "R3 status byte 1", int'(rx), 'hA5);
    chk(oe == 1'b1, "R10 oe on during status data", int'(oe), 1);
    xb(8'h00, rx, oe);
    chk(rx == 8'hA5, "R3 status byte 2", int'(rx), 'hA5);
    status_in = 8'h3C;
    xb(8'h00, rx, oe);
    chk(rx == 8'h3C, "R3 status byte 3 updated", int'(rx), 'h3C);
    desel();
    chk(miso_oe == 1'b0, "R1 oe off after deselect", int'(miso_oe), 0);

    // R4 status write, extra bytes ignored
    w0 = n_swr;
    mode3 = 1'b1;
    sel(); xb(8'h01, rx, oe); xb(8'h8C, rx, oe); xb(8'h77, rx, oe); desel();
    chk(n_swr == w0 + 1, "R4 one status write", n_swr - w0, 1);
    chk(last_swr == 8'h8C, "R4 status data", int'(last_swr), 'h8C);

    // R9 invalid opcode followed by write-like bytes
    s0 = n_set; c0 = n_clr; w0 = n_swr;
    sel();
    xb(8'h0B, rx, oe); xb(8'h02, rx, oe); xb(8'h00, rx, oe);
    xb(8'h10, rx, oe); xb(8'h5A, rx, oe);
    desel();
    chk(oe == 1'b0 && n_set == s0 && n_clr == c0 && n_swr == w0,
        "R9 invalid opcode no effect", int'(oe), 0);
    read_burst(16'h0010, 2, "R9 array unchanged after invalid opcode");

    // R8 partial write byte discarded
    mode3 = 1'b0;
    sel();
    xb(8'h02, rx, oe); xb(8'h00, rx, oe); xb(8'h20, rx, oe);
    xb(8'hC3, rx, oe); model_mem[16'h020] = 8'hC3;
    bits(8'h00, 5, rx, oe);
    desel();
    read_burst(16'h0020, 2, "R8 partial byte discarded");

    // R11 blocked window inside a burst
    blk_lo = 'h0F2; blk_hi = 'h0F4;
    write_burst(16'h00F0, 6, 99);
    blk_lo = 0; blk_hi = 0;
    read_burst(16'h00F0, 6, "R11 blocked bytes dropped, address advances");

    // R7 write wrap at the top address
    write_burst(16'h07FE, 4, 53);
    mode3 = 1'b1;
    read_burst(16'h07FE, 4, "R7 write wrap");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule